// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor with Data Mute

This block watches the recovered serial data of several receive channels and decides, channel by channel, whether the incoming signal can be trusted. An internal activity detector flags a loss when the sampled bit stream stops toggling for a short interval. It only withdraws that flag after a much longer stretch of steady activity. A second, external loss source comes from an optical module's signal-detect pin. That pin is synchronised and then compared against a per-channel polarity bit, so modules with either active level can be used.

The two sources are merged into one loss indication per channel. While a loss is active, the channel's registered data output is forced to zero, so random line noise never reaches the framer downstream. A sticky status bit records every loss until it is cleared by a write-one pulse. A per-channel disable parks the detector and keeps the channel's outputs quiet. All time intervals are parameters counted in sample-clock cycles. At a 77.76 MHz sample clock, the defaults of 194 and 9953 cycles correspond to about 2.5 µs and 128 µs.

Top module: `los_guard`

## Requirements
- R1: With the internal detector enabled, a channel whose sampled data shows no transition for DECL_CYC consecutive samples reports `los_out` high after the edge that takes the last of those samples.
- R2: A declared internal loss clears after CLR_CYC consecutive samples in which no DECL_CYC no-transition gap completes. Each completed gap restarts the count. This also applies when the gap completes on the same sample that would otherwise have cleared the loss, and in that case the loss stays active.
- R3: After reset, every enabled channel starts with its internal loss declared. `rx_dout` and `los_stat` are zero during reset.
- R4: When `dlos_off` of a channel is high, its internal detector has no effect on `los_out` or on the data mute. The external path still acts.
- R5: External loss equals the synchronised `sd_in` XOR `sd_pol`. A change on `sd_in` reaches `los_out` after two clock edges, while `sd_pol` acts at once. Example: `sd_in`=0 with `sd_pol`=0 is no loss, and `sd_in`=0 with `sd_pol`=1 is loss.
- R6: `rx_dout` is `rx_din` delayed by one edge when the channel shows no loss. It is 0 on the edge after any cycle in which `los_out` is high.
- R7: `los_stat` is set on the edge after any cycle with `los_out` high. A `stat_clr` pulse clears it only when the loss is inactive. If the loss persists, setting wins over clearing.
- R8: With `chan_off` high, the channel shows `los_out`=0 and `rx_dout`=0, its `los_stat` holds its value, and its internal detector is parked in the declared state.
- R9: Channels are independent: the loss state of one channel does not affect any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_din | input | NCH | Sampled recovered data bit per channel |
| sd_in | input | NCH | Asynchronous signal-detect pin from the optical module |
| sd_pol | input | NCH | Polarity bit; XORed with the synchronised detect pin |
| dlos_off | input | NCH | Removes the internal activity detector from the loss decision |
| chan_off | input | NCH | Channel disable; parks the detector and silences outputs |
| stat_clr | input | NCH | Write-one-to-clear pulse for the sticky status |
| rx_dout | output | NCH | Registered, muted data output |
| los_out | output | NCH | Combined loss indication |
| los_stat | output | NCH | Sticky loss status |

## Verification
Two things can fall on the same sample. The completion of a no-transition gap can coincide with the last sample of the clearing window. A status clear pulse can also arrive while a loss is still present. The bench provokes the first case by toggling for CLR_CYC−DECL_CYC samples and then holding the data for DECL_CYC samples, so both events land on one edge. It then expects the loss to stay active and to need a full fresh window to clear. The second case is provoked by pulsing `stat_clr` during a declared internal loss. It is judged by the status remaining set.

// File: rtl/los_pkg.sv
package los_pkg;

   typedef enum logic {
      DET_LIVE = 1'b0,
      DET_LOST = 1'b1
   } det_state_e;

   localparam int unsigned DEF_DECL_CYC = 194;
   localparam int unsigned DEF_CLR_CYC  = 9953;
   localparam int unsigned DEF_SYNC     = 2;

endpackage

// File: rtl/los_sync_chain.sv
module los_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);

   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= d_async;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[STAGES-2:0], d_async};
         end
      end
   endgenerate

   assign d_sync = ff_q[STAGES-1];

endmodule

// File: rtl/los_activity_det.sv
module los_activity_det
   import los_pkg::*;
#(
   parameter int unsigned DECL_CYC = DEF_DECL_CYC,
   parameter int unsigned CLR_CYC  = DEF_CLR_CYC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic park,
   input  logic din,
   output logic lost
);

   localparam int unsigned GW = (DECL_CYC > 1) ? $clog2(DECL_CYC) : 1;
   localparam int unsigned RW = (CLR_CYC > 1)  ? $clog2(CLR_CYC)  : 1;
   localparam logic [GW-1:0] GAP_LAST = GW'(DECL_CYC - 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(CLR_CYC - 1);

   logic          prev_q;
   logic [GW-1:0] gap_q;
   logic [RW-1:0] run_q;
   det_state_e    st_q;

   logic toggled;
   logic gap_done;

   assign toggled  = din ^ prev_q;
   assign gap_done = !toggled && (gap_q == GAP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         gap_q  <= '0;
      end else if (park) begin
         prev_q <= 1'b0;
         gap_q  <= '0;
      end else begin
         prev_q <= din;
         if (toggled)       gap_q <= '0;
         else if (!gap_done) gap_q <= gap_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= DET_LOST;
         run_q <= '0;
      end else if (park) begin
         st_q  <= DET_LOST;
         run_q <= '0;
      end else begin
         unique case (st_q)
            DET_LIVE: begin
               run_q <= '0;
               if (gap_done) st_q <= DET_LOST;
            end
            DET_LOST: begin
               if (gap_done) begin
                  run_q <= '0;
               end else if (run_q == RUN_LAST) begin
                  run_q <= '0;
                  st_q  <= DET_LIVE;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
            default: st_q <= DET_LOST;
         endcase
      end
   end

   assign lost = (st_q == DET_LOST);

endmodule

// File: rtl/los_lane.sv
module los_lane
   import los_pkg::*;
#(
   parameter int unsigned DECL_CYC = DEF_DECL_CYC,
   parameter int unsigned CLR_CYC  = DEF_CLR_CYC,
   parameter int unsigned SYNC     = DEF_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic sd,
   input  logic pol,
   input  logic dlos_off,
   input  logic chan_off,
   input  logic stat_clr,
   output logic dout,
   output logic los,
   output logic stat
);

   logic sd_s;
   logic int_lost;
   logic ext_lost;
   logic any_lost;
   logic dout_q;
   logic stat_q;

   los_sync_chain #(.STAGES(SYNC)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sd),
      .d_sync  (sd_s)
   );

   los_activity_det #(.DECL_CYC(DECL_CYC), .CLR_CYC(CLR_CYC)) i_det (
      .clk   (clk),
      .rst_n (rst_n),
      .park  (chan_off),
      .din   (din),
      .lost  (int_lost)
   );

   assign ext_lost = sd_s ^ pol;
   assign any_lost = (int_lost && !dlos_off) || ext_lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         dout_q <= (chan_off || any_lost) ? 1'b0 : din;
         if (!chan_off) stat_q <= any_lost || (stat_q && !stat_clr);
      end
   end

   assign dout = dout_q;
   assign los  = any_lost && !chan_off;
   assign stat = stat_q;

endmodule

// File: rtl/los_guard.sv
module los_guard
   import los_pkg::*;
#(
   parameter int unsigned NCH      = 4,
   parameter int unsigned DECL_CYC = DEF_DECL_CYC,
   parameter int unsigned CLR_CYC  = DEF_CLR_CYC,
   parameter int unsigned SYNC     = DEF_SYNC
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] rx_din,
   input  logic [NCH-1:0] sd_in,
   input  logic [NCH-1:0] sd_pol,
   input  logic [NCH-1:0] dlos_off,
   input  logic [NCH-1:0] chan_off,
   input  logic [NCH-1:0] stat_clr,
   output logic [NCH-1:0] rx_dout,
   output logic [NCH-1:0] los_out,
   output logic [NCH-1:0] los_stat
);

   initial begin
      assert (NCH >= 1) else $error("los_guard: NCH must be at least 1");
      assert (DECL_CYC >= 2) else $error("los_guard: DECL_CYC must be at least 2");
      assert (CLR_CYC > DECL_CYC) else $error("los_guard: CLR_CYC must exceed DECL_CYC");
      assert (SYNC >= 2) else $error("los_guard: SYNC needs two or more stages");
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         los_lane #(
            .DECL_CYC (DECL_CYC),
            .CLR_CYC  (CLR_CYC),
            .SYNC     (SYNC)
         ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (rx_din[c]),
            .sd       (sd_in[c]),
            .pol      (sd_pol[c]),
            .dlos_off (dlos_off[c]),
            .chan_off (chan_off[c]),
            .stat_clr (stat_clr[c]),
            .dout     (rx_dout[c]),
            .los      (los_out[c]),
            .stat     (los_stat[c])
         );
      end
   endgenerate

endmodule

// File: rtl/los_guard_chk.sv
module los_guard_chk #(
   parameter int unsigned NCH  = 4,
   parameter int unsigned SYNC = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] rx_din,
   input logic [NCH-1:0] sd_in,
   input logic [NCH-1:0] sd_pol,
   input logic [NCH-1:0] dlos_off,
   input logic [NCH-1:0] chan_off,
   input logic [NCH-1:0] stat_clr,
   input logic [NCH-1:0] rx_dout,
   input logic [NCH-1:0] los_out,
   input logic [NCH-1:0] los_stat
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_a
         // R6: muted after any loss cycle or while disabled
         p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (los_out[c] || chan_off[c]) |=> !rx_dout[c]);
         // R6: clean channel passes data with one edge of delay
         p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!los_out[c] && !chan_off[c]) |=> (rx_dout[c] == $past(rx_din[c])));
         // R7: status follows any visible loss
         p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            los_out[c] |=> los_stat[c]);
         // R7: clear pulse without loss empties the status
         p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (los_stat[c] && stat_clr[c] && !los_out[c] && !chan_off[c]) |=> !los_stat[c]);
         // R8: disabled channel holds status
         p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            chan_off[c] |=> $stable(los_stat[c]));
         // R5: external detect after two synchroniser stages
         if (SYNC == 2) begin : g_ext
            p_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (since_rst >= 2'd2 && !chan_off[c] && ($past(sd_in[c], 2) ^ sd_pol[c]))
               |-> los_out[c]);
         end
      end
   endgenerate

   wire unused_ok = ^{dlos_off};

endmodule

bind los_guard los_guard_chk #(.NCH(NCH), .SYNC(SYNC)) i_chk (.*);

// File: tb/test_los_guard.sv
module test_los_guard;

   localparam int unsigned NCH  = 4;
   localparam int unsigned DECL = 8;
   localparam int unsigned CLRC = 40;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] rx_din = '0, sd_in = '0, sd_pol = '0;
   logic [NCH-1:0] dlos_off = '0, chan_off = '0, stat_clr = '0;
   logic [NCH-1:0] rx_dout, los_out, los_stat;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   los_guard #(.NCH(NCH), .DECL_CYC(DECL), .CLR_CYC(CLRC)) i_los_guard (
      .clk(clk), .rst_n(rst_n), .rx_din(rx_din), .sd_in(sd_in), .sd_pol(sd_pol),
      .dlos_off(dlos_off), .chan_off(chan_off), .stat_clr(stat_clr),
      .rx_dout(rx_dout), .los_out(los_out), .los_stat(los_stat)
   );

   // external path table: {sd, pol}
   localparam logic [1:0] EXT_TAB [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic prev_sd;
      logic [NCH-1:0] v;
      repeat (3) tick();
      chk("R3 rx_dout in reset", rx_dout, '0);
      chk("R3 los_stat in reset", los_stat, '0);
      rst_n = 1'b1;
      #1;
      chk("R3 declared after reset", los_out, 4'hF);

      // toggle, then gap finishing on the clear sample (R2 coincidence)
      for (int k = 1; k <= int'(CLRC - DECL); k++) begin
         rx_din = (k % 2 == 1) ? 4'hF : 4'h0;
         tick();
      end
      repeat (DECL) tick();
      chk("R2 gap on clearing sample keeps loss", los_out, 4'hF);
      chk("R7 status set by loss", los_stat, 4'hF);
      for (int k = 1; k <= int'(CLRC); k++) begin
         rx_din = (k % 2 == 1) ? 4'hF : 4'h0;
         tick();
         if (k == int'(CLRC) - 1) chk("R2 not yet cleared", los_out, 4'hF);
         if (k == int'(CLRC))     chk("R2 cleared after window", los_out, 4'h0);
      end

      // R6 passthrough
      rx_din = 4'h5; tick();
      chk("R6 pass 5", rx_dout, 4'h5);
      rx_din = 4'hA; tick();
      chk("R6 pass A", rx_dout, 4'hA);

      // R1 declare after DECL constant samples
      repeat (DECL - 1) tick();
      chk("R1 before threshold", los_out, 4'h0);
      tick();
      chk("R1 declared at threshold", los_out, 4'hF);
      stat_clr = 4'hF;
      tick();
      chk("R6 muted during internal loss", rx_dout, 4'h0);
      chk("R7 set wins over clear", los_stat, 4'hF);
      stat_clr = 4'h0;

      // R9 only channels 0 and 1 recover
      for (int k = 1; k <= int'(CLRC); k++) begin
         rx_din = {2'b10, (k % 2 == 1) ? 2'b01 : 2'b10};
         tick();
         if (k == int'(CLRC) - 1) chk("R9 all still lost", los_out, 4'hF);
         if (k == int'(CLRC))     chk("R9 only active lanes clear", los_out, 4'hC);
      end
      rx_din = {2'b10, 2'b01};
      stat_clr = 4'h3;
      tick();
      chk("R7 write-one clear on idle lanes", los_stat, 4'hC);
      stat_clr = 4'h0;

      // R4 internal detector disabled
      dlos_off = 4'hC;
      #1;
      chk("R4 internal loss masked", los_out, 4'h0);
      rx_din = {2'b10, 2'b10};
      tick();
      chk("R4 data passes while masked", rx_dout, 4'hA);

      // R5 table walk, internal detector off everywhere
      dlos_off = 4'hF;
      rx_din   = 4'h6;
      prev_sd  = 1'b0;
      for (int r = 0; r < 4; r++) begin
         sd_in  = {NCH{EXT_TAB[r][1]}};
         sd_pol = {NCH{EXT_TAB[r][0]}};
         tick();
         chk("R5 one edge: old detect with new polarity", los_out,
             {NCH{prev_sd ^ EXT_TAB[r][0]}});
         tick();
         v = {NCH{EXT_TAB[r][1] ^ EXT_TAB[r][0]}};
         chk("R5 two edges: detect xor polarity", los_out, v);
         tick();
         chk("R6 external mute", rx_dout, (v == 0) ? 4'h6 : 4'h0);
         prev_sd = EXT_TAB[r][1];
      end

      // R8 channel disable
      sd_in = 4'h1; sd_pol = 4'h0;
      repeat (3) tick();
      chk("R8 lane 0 lost before disable", los_out, 4'h1);
      chan_off = 4'h1;
      #1;
      chk("R8 disabled lane shows no loss", los_out, 4'h0);
      stat_clr = 4'h1;
      rx_din = 4'hF;
      tick();
      chk("R8 status held while disabled", los_stat & 4'h1, 4'h1);
      chk("R8 disabled lane output quiet", rx_dout, 4'hE);
      stat_clr = 4'h0;
      chan_off = 4'h0;
      #1;
      chk("R8 loss back after enable", los_out, 4'h1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule